// File: doc/BRIEF.md
# Binary Extension Field Multiplier (Polynomial Basis)

This block multiplies two elements of GF(2^N) in one combinational pass. Both operands and the result are N-bit vectors. Bit i of each vector is the coefficient of x^i, and the field is defined by an irreducible polynomial of degree N. The width and the polynomial are fixed when the block is elaborated. The polynomial can be any trinomial or pentanomial. It is supplied without its implicit x^N term, so the default for N = 8 is 8'h1B, which encodes x^8 + x^4 + x^3 + x + 1.

Internally the block forms a ladder of N shifted copies of operand `a`, and each copy is reduced as soon as it is made. A copy whose top bit was set is shifted and then XORed with the polynomial's low bits. Each rung is gated by one bit of operand `b`, and a balanced binary XOR tree adds the gated rungs together. The gating uses N*N AND gates and the tree is ceil(log2 N) levels deep.

Elaboration stops with an error in three cases: the width is out of range, the constant term of the polynomial is missing, or the polynomial has neither three nor five terms.

Top module: `gf2n_poly_mul`

## Requirements
- R1: The output `c` equals a(x)·b(x) mod p(x), with coefficients in GF(2). With the default 8'h1B, 0x57·0x83 = 0xC1 and 0x53·0xCA = 0x01.
- R2: If either operand is all zeros, `c` is all zeros.
- R3: If one operand is the unit element (only bit 0 set), `c` equals the other operand unchanged.
- R4: The product is commutative: swapping `a` and `b` leaves `c` unchanged.
- R5: If `b` is x (only bit 1 set), `c` is `a` shifted left by one bit, XORed with the polynomial's low N bits when bit N-1 of `a` was 1.
- R6: The product distributes over field addition, which is bitwise XOR: a·(b1 XOR b2) = a·b1 XOR a·b2.
- R7: With an irreducible polynomial, two nonzero operands never give a zero product.
- R8: The same structure is correct for a trinomial field: N = 9 with 9'h011 (x^9 + x^4 + 1) matches the reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Multiplicand field element; bit i is the coefficient of x^i |
| b | input | N | Multiplier field element; bit i selects rung i of the ladder |
| c | output | N | Reduced product a·b mod p(x) |

## Verification
The bench compares every product against a Horner-order reference that reduces once per bit, starting from the top bit of `b`. It also targets the corner operands 0, 1, x and all-ones, where a ladder with a wrong reduction condition, such as testing the bit after the shift or dropping the final rung, gives wrong top bits or leaks an unreduced x^N term. The known pairs 0x57·0x83 and 0x53·0xCA, together with swapped operands and split multipliers, catch a mis-indexed gate or a tree that pairs leaves twice or drops a padded leaf. A second instance built on a trinomial catches polynomial handling that only works for the default pentanomial.

// File: rtl/gf_mul_pkg.sv
package gf_mul_pkg;

    localparam int unsigned GF_MAX_N = 64;

    // Number of set bits among the low n bits of a polynomial tail.
    function automatic int unsigned tail_weight(input logic [GF_MAX_N-1:0] tail,
                                                input int unsigned n);
        int unsigned cnt;
        cnt = 0;
        for (int unsigned k = 0; k < GF_MAX_N; k++) begin
            if (k < n && tail[k]) cnt++;
        end
        return cnt;
    endfunction

    // A trinomial tail has two ones and a pentanomial tail has four;
    // the constant term must be present in both cases.
    function automatic bit tail_is_legal(input logic [GF_MAX_N-1:0] tail,
                                         input int unsigned n);
        int unsigned w;
        w = tail_weight(tail, n);
        return tail[0] && (w == 2 || w == 4);
    endfunction

    // Depth of a binary tree that covers the given number of leaves.
    function automatic int unsigned tree_depth(input int unsigned leaves);
        int unsigned d;
        d = 0;
        while ((1 << d) < leaves) d++;
        return d;
    endfunction

endpackage

// File: rtl/gf_shift_reduce.sv
// One rung of the ladder: multiply by x and fold the overflow back in.
module gf_shift_reduce #(
    parameter int unsigned N    = 8,
    parameter logic [N-1:0] POLY = 8'h1B
) (
    input  logic [N-1:0] z_in,
    output logic [N-1:0] z_out
);
    logic [N-1:0] shifted;
    logic         carry;

    always_comb begin
        carry   = z_in[N-1];
        shifted = {z_in[N-2:0], 1'b0};
        z_out   = carry ? (shifted ^ POLY) : shifted;
    end
endmodule

// File: rtl/gf_pp_ladder.sv
// Builds z0..z(N-1) and gates each with one bit of b.
module gf_pp_ladder #(
    parameter int unsigned N    = 8,
    parameter logic [N-1:0] POLY = 8'h1B
) (
    input  logic [N-1:0]         a,
    input  logic [N-1:0]         b,
    output logic [N-1:0][N-1:0]  pp
);
    logic [N-1:0][N-1:0] rung;

    assign rung[0] = a;

    for (genvar i = 1; i < N; i++) begin : g_rung
        gf_shift_reduce #(.N(N), .POLY(POLY)) u_step (
            .z_in  (rung[i-1]),
            .z_out (rung[i])
        );
    end

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign pp[i] = rung[i] & {N{b[i]}};
    end
endmodule

// File: rtl/gf_xor_tree.sv
// Balanced binary XOR tree; leaves past LEAVES are padded with zero.
module gf_xor_tree #(
    parameter int unsigned W      = 8,
    parameter int unsigned LEAVES = 8
) (
    input  logic [LEAVES-1:0][W-1:0] leaf,
    output logic [W-1:0]             sum
);
    import gf_mul_pkg::*;

    localparam int unsigned DEPTH = tree_depth(LEAVES);
    localparam int unsigned SPAN  = 1 << DEPTH;

    for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
        logic [(SPAN >> l)-1:0][W-1:0] v;
        if (l == 0) begin : g_base
            for (genvar j = 0; j < SPAN; j++) begin : g_leaf
                if (j < LEAVES) begin : g_real
                    assign v[j] = leaf[j];
                end else begin : g_pad
                    assign v[j] = '0;
                end
            end
        end else begin : g_node
            for (genvar j = 0; j < (SPAN >> l); j++) begin : g_pair
                assign v[j] = g_lvl[l-1].v[2*j] ^ g_lvl[l-1].v[2*j+1];
            end
        end
    end

    assign sum = g_lvl[DEPTH].v[0];
endmodule

// File: rtl/gf2n_poly_mul.sv
module gf2n_poly_mul #(
    parameter int unsigned N    = 8,
    parameter logic [N-1:0] POLY = 8'h1B
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] c
);
    import gf_mul_pkg::*;

    localparam logic [GF_MAX_N-1:0] TAIL = GF_MAX_N'(POLY);

    if (N < 2 || N > GF_MAX_N) begin : g_bad_width
        $error("gf2n_poly_mul: width N out of range");
    end
    if (!tail_is_legal(TAIL, N)) begin : g_bad_poly
        $error("gf2n_poly_mul: polynomial must be a trinomial or pentanomial with constant term");
    end

    logic [N-1:0][N-1:0] pp;

    gf_pp_ladder #(.N(N), .POLY(POLY)) u_ladder (
        .a  (a),
        .b  (b),
        .pp (pp)
    );

    gf_xor_tree #(.W(N), .LEAVES(N)) u_tree (
        .leaf (pp),
        .sum  (c)
    );
endmodule

// File: rtl/gf2n_poly_mul_chk.sv
module gf2n_poly_mul_chk #(
    parameter int unsigned N    = 8,
    parameter logic [N-1:0] POLY = 8'h1B
) (
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic [N-1:0] c
);
    localparam logic [N-1:0] UNIT = {{(N-1){1'b0}}, 1'b1};
    localparam logic [N-1:0] XVAL = {{(N-2){1'b0}}, 2'b10};

    logic [N-1:0] times_x;

    always_comb begin
        times_x = {a[N-2:0], 1'b0} ^ (a[N-1] ? POLY : '0);

        // R2
        zero_b_chk: assert (b != '0 || c == '0)
            else $error("zero multiplier gave nonzero product");
        // R2
        zero_a_chk: assert (a != '0 || c == '0)
            else $error("zero multiplicand gave nonzero product");
        // R3
        unit_b_chk: assert (b != UNIT || c == a)
            else $error("unit multiplier changed the operand");
        // R3
        unit_a_chk: assert (a != UNIT || c == b)
            else $error("unit multiplicand changed the operand");
        // R5
        times_x_chk: assert (b != XVAL || c == times_x)
            else $error("multiply by x mismatched");
        // R7
        no_zero_div_chk: assert (a == '0 || b == '0 || c != '0)
            else $error("nonzero operands gave zero product");
    end
endmodule

bind gf2n_poly_mul gf2n_poly_mul_chk #(.N(N), .POLY(POLY)) u_chk (
    .a (a),
    .b (b),
    .c (c)
);

// File: tb/gf2n_poly_mul_tb.sv
module gf2n_poly_mul_tb;

    localparam int unsigned NP = 8;
    localparam logic [NP-1:0] PP = 8'h1B;
    localparam int unsigned NT = 9;
    localparam logic [NT-1:0] PT = 9'h011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [NP-1:0] a8 = '0, b8 = '0, c8;
    logic [NT-1:0] a9 = '0, b9 = '0, c9;

    gf2n_poly_mul #(.N(NP), .POLY(PP)) u_dut (.a(a8), .b(b8), .c(c8));
    gf2n_poly_mul #(.N(NT), .POLY(PT)) u_dut_tri (.a(a9), .b(b9), .c(c9));

    typedef struct {
        bit          tri_sel;
        logic [15:0] opa;
        logic [15:0] opb;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t       sb_q[$];
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    // Horner-order reference: scan b from the top bit down.
    function automatic logic [15:0] ref_mul(input int n, input logic [15:0] p,
                                            input logic [15:0] x, input logic [15:0] y);
        logic [15:0] r, mask;
        bit          top;
        mask = (16'd1 << n) - 16'd1;
        r    = '0;
        for (int i = n - 1; i >= 0; i--) begin
            top = r[n-1];
            r   = (r << 1) & mask;
            if (top) r = r ^ p;
            if (y[i]) r = r ^ x;
        end
        return r;
    endfunction

    task automatic drive(input bit tsel, input logic [15:0] x, input logic [15:0] y,
                         input logic [15:0] exp, input string req);
        item_t it;
        @(posedge clk);
        if (tsel) begin
            a9 = x[NT-1:0];
            b9 = y[NT-1:0];
        end else begin
            a8 = x[NP-1:0];
            b8 = y[NP-1:0];
        end
        it.tri_sel = tsel;
        it.opa = x;
        it.opb = y;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic mul8(input logic [15:0] x, input logic [15:0] y, input string req);
        drive(1'b0, x, y, ref_mul(NP, 16'(PP), x, y), req);
    endtask

    // Monitor: compare away from the driving edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t       it;
            logic [15:0] got;
            it  = sb_q.pop_front();
            got = it.tri_sel ? 16'(c9) : 16'(c8);
            checks++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s: a=%h b=%h actual=%h expected=%h",
                         it.req, it.opa, it.opb, got, it.exp);
            end
        end
    end

    initial begin
        // reset state: operands held at zero
        repeat (3) @(posedge clk);
        drive(1'b0, 16'h0, 16'h0, 16'h0, "R2 reset");
        rst = 1'b0;

        // R1 known pairs
        drive(1'b0, 16'h57, 16'h83, 16'hC1, "R1 known");
        drive(1'b0, 16'h53, 16'hCA, 16'h01, "R1 known");
        drive(1'b0, 16'hFF, 16'hFF, ref_mul(NP, 16'(PP), 16'hFF, 16'hFF), "R1 all-ones");

        // R2 zero, R3 unit, R5 times-x, over every a
        for (int v = 0; v < 256; v++) begin
            mul8(16'(v), 16'h00, "R2 zero b");
            mul8(16'h00, 16'(v), "R2 zero a");
            drive(1'b0, 16'(v), 16'h01, 16'(v), "R3 unit b");
            drive(1'b0, 16'h01, 16'(v), 16'(v), "R3 unit a");
            mul8(16'(v), 16'h02, "R5 times x");
            mul8(16'(v), 16'hFF, "R1 all-ones b");
        end

        // R1 random, R4 swapped, R6 split multiplier, R7 nonzero product
        for (int k = 0; k < 300; k++) begin
            logic [15:0] x, y, y1, y2;
            x  = 16'($urandom_range(1, 255));
            y  = 16'($urandom_range(1, 255));
            y1 = 16'($urandom_range(0, 255));
            y2 = 16'($urandom_range(0, 255));
            mul8(x, y, "R1 random");
            drive(1'b0, y, x, ref_mul(NP, 16'(PP), x, y), "R4 commute");
            drive(1'b0, x, y1 ^ y2,
                  ref_mul(NP, 16'(PP), x, y1) ^ ref_mul(NP, 16'(PP), x, y2), "R6 distribute");
            if (ref_mul(NP, 16'(PP), x, y) == 16'h0) begin
                checks++;
                fails++;
                $display("FAIL R7: a=%h b=%h actual=0000 expected=nonzero", x, y);
            end
        end

        // R8 trinomial instance
        drive(1'b1, 16'h1FF, 16'h1FF, ref_mul(NT, 16'(PT), 16'h1FF, 16'h1FF), "R8 all-ones");
        drive(1'b1, 16'h100, 16'h002, 16'h011, "R8 overflow fold");
        drive(1'b1, 16'h0AB, 16'h001, 16'h0AB, "R8 unit");
        for (int k = 0; k < 300; k++) begin
            logic [15:0] x, y;
            x = 16'($urandom_range(0, 511));
            y = 16'($urandom_range(0, 511));
            drive(1'b1, x, y, ref_mul(NT, 16'(PT), x, y), "R8 random");
        end

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule